// File: doc/BRIEF.md
# Protected Frame Transmit Sequencer

This block turns a byte frame waiting in a transmit FIFO into a single serial bit stream. The bytes go out on the line and, at the same moment, into a bit-serial CRC32. They also go, as 4-bit symbols, into a systematic RS(15,11) encoder over GF(16). Each time the encoder has taken eleven symbols, data output and CRC accumulation pause while the four check symbols go out. After the last data byte, the four CRC bytes follow on the line and are also fed to the encoder. Check symbols for the final, possibly short, block close the frame.

Every bit on the line is XORed with an additive pseudo-random sequence, so that long runs of equal bits are broken up. Each bit slot is granted by a bit-rate enable pulse. At the end of a frame the CRC, the encoder and the scrambler are all reset. The sequencer then waits for the next frame-available indication.

Top module: `ftx_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after its release, ser_vld, frm_done and rd_en are 0.
- R2: In idle with frm_avail high, the block latches frm_len and pops exactly frm_len bytes (rd_en high for one cycle per byte, with rd_data taken in that cycle). Each byte is sent as two symbols, low nibble first, and every symbol goes out least significant bit first.
- R3: After every 11 payload symbols, 4 check symbols are sent, and no byte is popped while they go out. The check symbols are the remainder of m(x)·x^4 divided by g(x) = (x+2)(x+4)(x+8)(x+3) over GF(16) with field polynomial x^4+x+1, with the first payload symbol taken as the highest-degree coefficient. They are sent highest-degree coefficient first.
- R4: After the data, the CRC32 goes out: reflected polynomial 0xEDB88320, initial value all ones, final inversion, sent least significant bit first. Its 8 nibbles are payload symbols for the encoder.
- R5: If the payload does not fill its final block, that block is completed with zero symbols that are encoded but not sent, and its check symbols end the frame. A payload that is an exact multiple of 11 symbols adds nothing after its last check burst.
- R6: Each line bit equals the raw bit XOR k, where k = s[6]^s[3] for a 7-bit state s. After each sent bit, s becomes {s[5:0],k}. s starts at 7'h7F for every frame.
- R7: Exactly one line bit is sent per bit_en pulse while a frame is on the line. ser_vld is high in the cycle after that pulse, and never in a cycle not preceded by bit_en.
- R8: frm_done is a one-cycle pulse that coincides with the ser_vld of the last bit of the frame.
- R9: A frame with frm_len = 0 pops nothing. It sends only the 32 CRC bits, which are all zero before scrambling, and then one check burst.
- R10: With no frame in progress, bit_en produces no ser_vld and no rd_en.
- R11: Sending the same frame twice gives the same line stream both times, because the CRC, the encoder and the scrambler restart for every frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frm_avail | input | 1 | A whole frame is waiting in the FIFO |
| frm_len | input | LEN_W | Data bytes in the waiting frame |
| rd_data | input | 8 | FIFO head byte (show-ahead) |
| rd_en | output | 1 | Pop the FIFO head this cycle |
| bit_en | input | 1 | Bit slot grant |
| ser_bit | output | 1 | Scrambled line bit |
| ser_vld | output | 1 | ser_bit carries a bit this cycle |
| frm_done | output | 1 | Last bit of the frame is on ser_bit |

## Verification
The bench aims at frame lengths where a check burst lands in the middle of a byte, inside the CRC, or exactly on the last CRC nibble. A design that paused on the wrong symbol count, or padded a block that was already full, would shift or lengthen the stream. A zero-length frame exposes a sequencer that pops anyway or skips the CRC. Sparse and bursty bit enables expose one that drops or repeats bits. Sending the same frame twice exposes a scrambler or CRC that is not re-seeded, because the second stream would then differ.

// File: rtl/ftx_pkg.sv
package ftx_pkg;
  localparam int SYM_W    = 4;
  localparam int PAR_SYMS = 4;
  localparam logic [4:0] GF_POLY = 5'b10011;

  typedef enum logic [2:0] {S_IDLE, S_DATA, S_CRC, S_PAD, S_PAR} tx_state_e;
  typedef enum logic [1:0] {R_DATA, R_CRC, R_END} resume_e;

  function automatic logic [3:0] gf_mul(input logic [3:0] a, input logic [3:0] b);
    logic [3:0] acc;
    logic [3:0] x;
    acc = '0;
    x   = a;
    for (int i = 0; i < 4; i++) begin
      if (b[i]) acc = acc ^ x;
      x = x[3] ? ({x[2:0], 1'b0} ^ GF_POLY[3:0]) : {x[2:0], 1'b0};
    end
    return acc;
  endfunction

  // coefficients g3..g0 of the monic degree-4 generator, roots alpha^1..alpha^4
  function automatic logic [15:0] gen_poly();
    logic [3:0] c [0:4];
    logic [3:0] r;
    c[0] = 4'h1;
    for (int j = 1; j <= 4; j++) c[j] = 4'h0;
    r = 4'h1;
    for (int i = 1; i <= 4; i++) begin
      r = gf_mul(r, 4'h2);
      for (int j = 4; j >= 1; j--) c[j] = c[j-1] ^ gf_mul(c[j], r);
      c[0] = gf_mul(c[0], r);
    end
    return {c[3], c[2], c[1], c[0]};
  endfunction
endpackage

// File: rtl/ftx_crc32.sv
module ftx_crc32 #(
  parameter logic [31:0] POLY_REF = 32'hEDB88320
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic absorb,
  input  logic emit,
  input  logic din,
  output logic out_bit
);
  logic [31:0] crc_q, crc_d;

  always_comb begin
    crc_d = crc_q;
    if (clr)         crc_d = '1;
    else if (absorb) crc_d = (crc_q >> 1) ^ ({32{crc_q[0] ^ din}} & POLY_REF);
    else if (emit)   crc_d = {1'b1, crc_q[31:1]};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crc_q <= '1;
    else        crc_q <= crc_d;
  end

  assign out_bit = ~crc_q[0];
endmodule

// File: rtl/ftx_rs_enc.sv
module ftx_rs_enc import ftx_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             feed,
  input  logic             drain,
  input  logic [SYM_W-1:0] sym,
  output logic [SYM_W-1:0] par_sym
);
  localparam logic [15:0] GEN = gen_poly();

  logic [SYM_W-1:0] p_q [PAR_SYMS];
  logic [SYM_W-1:0] p_d [PAR_SYMS];
  logic [SYM_W-1:0] fb;

  assign fb      = sym ^ p_q[PAR_SYMS-1];
  assign par_sym = p_q[PAR_SYMS-1];

  always_comb begin
    for (int k = 0; k < PAR_SYMS; k++) begin
      p_d[k] = p_q[k];
      if (clr) begin
        p_d[k] = '0;
      end else if (feed) begin
        p_d[k] = (k == 0) ? gf_mul(fb, GEN[3:0])
                          : p_q[(k == 0) ? 0 : k-1] ^ gf_mul(fb, GEN[4*k +: 4]);
      end else if (drain) begin
        p_d[k] = (k == 0) ? '0 : p_q[(k == 0) ? 0 : k-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < PAR_SYMS; k++) p_q[k] <= '0;
    end else begin
      for (int k = 0; k < PAR_SYMS; k++) p_q[k] <= p_d[k];
    end
  end
endmodule

// File: rtl/ftx_scrambler.sv
module ftx_scrambler #(
  parameter int W   = 7,
  parameter int TAP = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic adv,
  output logic key
);
  logic [W-1:0] s_q, s_d;

  assign key = s_q[W-1] ^ s_q[TAP-1];

  always_comb begin
    s_d = s_q;
    if (clr)      s_d = '1;
    else if (adv) s_d = {s_q[W-2:0], key};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s_q <= '1;
    else        s_q <= s_d;
  end
endmodule

// File: rtl/ftx_seq.sv
module ftx_seq import ftx_pkg::*; #(
  parameter int LEN_W    = 8,
  parameter int BLK_SYMS = 11
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             frm_avail,
  input  logic [LEN_W-1:0] frm_len,
  input  logic [7:0]       rd_data,
  output logic             rd_en,
  input  logic             bit_en,
  output logic             ser_bit,
  output logic             ser_vld,
  output logic             frm_done
);
  localparam int CNT_W    = $clog2(BLK_SYMS + 1);
  localparam int CRC_NIBS = 32 / SYM_W;

  tx_state_e        st_q, st_d;
  resume_e          after_q, after_d, nxt;
  logic [7:0]       byte_q, byte_d;
  logic [LEN_W-1:0] left_q, left_d;
  logic             hi_q, hi_d;
  logic [1:0]       bcnt_q, bcnt_d, par_q, par_d;
  logic [2:0]       col_q, col_d, crcn_q, crcn_d;
  logic [CNT_W-1:0] blk_q, blk_d, blk_inc;
  logic             sbit_q, sbit_d, svld_q, done_q, done_d;

  logic emitting, sym_end, pay_end, blk_wrap, raw_bit, key, crc_bit;
  logic sub_clr, crc_abs, crc_emit, rs_feed, rs_drain;
  logic [SYM_W-1:0] nib, rs_sym, par_sym;

  ftx_crc32 u_crc (.clk(clk), .rst_n(rst_n), .clr(sub_clr), .absorb(crc_abs),
                   .emit(crc_emit), .din(raw_bit), .out_bit(crc_bit));
  ftx_rs_enc u_rs (.clk(clk), .rst_n(rst_n), .clr(sub_clr), .feed(rs_feed),
                   .drain(rs_drain), .sym(rs_sym), .par_sym(par_sym));
  ftx_scrambler #(.W(7), .TAP(4)) u_scr (.clk(clk), .rst_n(rst_n), .clr(sub_clr),
                   .adv(emitting), .key(key));

  assign emitting = bit_en && (st_q == S_DATA || st_q == S_CRC || st_q == S_PAR);
  assign sym_end  = emitting && (bcnt_q == 2'd3);
  assign nib      = hi_q ? byte_q[7:4] : byte_q[3:0];
  assign blk_inc  = blk_q + CNT_W'(1);
  assign blk_wrap = (blk_inc == CNT_W'(BLK_SYMS));

  always_comb begin
    case (st_q)
      S_DATA:  raw_bit = nib[bcnt_q];
      S_CRC:   raw_bit = crc_bit;
      S_PAR:   raw_bit = par_sym[bcnt_q];
      default: raw_bit = 1'b0;
    endcase
  end

  // next-state process
  always_comb begin
    st_d = st_q;   after_d = after_q; byte_d = byte_q; left_d = left_q;
    hi_d = hi_q;   bcnt_d = bcnt_q;   par_d = par_q;   col_d = col_q;
    crcn_d = crcn_q; blk_d = blk_q;   done_d = 1'b0;
    rd_en = 1'b0;  sub_clr = 1'b0;    crc_abs = 1'b0;  crc_emit = 1'b0;
    rs_feed = 1'b0; rs_drain = 1'b0;  rs_sym = {raw_bit, col_q};
    pay_end = 1'b0; nxt = R_DATA;

    if (emitting) begin
      bcnt_d = bcnt_q + 2'd1;
      col_d  = {raw_bit, col_q[2:1]};
    end
    sbit_d = emitting ? (raw_bit ^ key) : 1'b0;

    case (st_q)
      S_IDLE: begin
        sub_clr = 1'b1;
        bcnt_d = '0; par_d = '0; crcn_d = '0; blk_d = '0; hi_d = 1'b0;
        if (frm_avail) begin
          left_d = frm_len;
          if (frm_len != '0) begin
            rd_en  = 1'b1;
            byte_d = rd_data;
            st_d   = S_DATA;
          end else begin
            st_d   = S_CRC;
          end
        end
      end
      S_DATA: begin
        crc_abs = emitting;
        if (sym_end) begin
          pay_end = 1'b1;
          if (!hi_q) begin
            hi_d = 1'b1;
          end else begin
            hi_d   = 1'b0;
            left_d = left_q - LEN_W'(1);
            if (left_q == LEN_W'(1)) begin
              nxt = R_CRC;
            end else begin
              rd_en  = 1'b1;
              byte_d = rd_data;
            end
          end
        end
      end
      S_CRC: begin
        crc_emit = emitting;
        if (sym_end) begin
          pay_end = 1'b1;
          crcn_d  = crcn_q + 3'd1;
          nxt     = (crcn_q == 3'(CRC_NIBS - 1)) ? R_END : R_CRC;
        end
      end
      S_PAD: begin
        rs_feed = 1'b1;
        rs_sym  = '0;
        blk_d   = blk_wrap ? '0 : blk_inc;
        if (blk_wrap) begin
          st_d    = S_PAR;
          after_d = R_END;
          par_d   = '0;
        end
      end
      S_PAR: begin
        if (sym_end) begin
          rs_drain = 1'b1;
          par_d    = par_q + 2'd1;
          if (par_q == 2'(PAR_SYMS - 1)) begin
            case (after_q)
              R_DATA:  st_d = S_DATA;
              R_CRC:   st_d = S_CRC;
              default: begin st_d = S_IDLE; done_d = 1'b1; end
            endcase
          end
        end
      end
      default: st_d = S_IDLE;
    endcase

    if (pay_end) begin
      rs_feed = 1'b1;
      blk_d   = blk_wrap ? '0 : blk_inc;
      if (blk_wrap) begin
        st_d = S_PAR; after_d = nxt; par_d = '0;
      end else if (nxt == R_END) st_d = S_PAD;
      else if (nxt == R_CRC)     st_d = S_CRC;
      else                       st_d = S_DATA;
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE; after_q <= R_DATA; byte_q <= '0; left_q <= '0;
      hi_q <= 1'b0; bcnt_q <= '0; par_q <= '0; col_q <= '0; crcn_q <= '0;
      blk_q <= '0; sbit_q <= 1'b0; svld_q <= 1'b0; done_q <= 1'b0;
    end else begin
      st_q <= st_d; after_q <= after_d; byte_q <= byte_d; left_q <= left_d;
      hi_q <= hi_d; bcnt_q <= bcnt_d; par_q <= par_d; col_q <= col_d;
      crcn_q <= crcn_d; blk_q <= blk_d; sbit_q <= sbit_d; svld_q <= emitting;
      done_q <= done_d;
    end
  end

  assign ser_bit  = sbit_q;
  assign ser_vld  = svld_q;
  assign frm_done = done_q;
endmodule

// File: rtl/ftx_seq_chk.sv
module ftx_seq_chk import ftx_pkg::*; (
  input logic      clk,
  input logic      rst_n,
  input logic      bit_en,
  input logic      rd_en,
  input logic      ser_vld,
  input logic      frm_done,
  input tx_state_e st
);
  p_vld_from_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ser_vld |-> $past(bit_en));

  p_done_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |=> !frm_done);

  p_done_on_last_bit_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frm_done |-> ser_vld);

  p_no_pop_in_parity_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PAR) |-> !rd_en);

  p_pop_spacing_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> !rd_en);

  p_idle_silent_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |=> !ser_vld);
endmodule

bind ftx_seq ftx_seq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rd_en(rd_en),
  .ser_vld(ser_vld), .frm_done(frm_done), .st(st_q)
);

// File: tb/ftx_seq_test.sv
module ftx_seq_test;
  logic       clk, rst_n, frm_avail, bit_en;
  logic [7:0] frm_len, rd_data;
  logic       rd_en, ser_bit, ser_vld, frm_done;

  logic [7:0] mem [0:1023];
  int         rd_ptr;
  int         n_tests, n_fail;
  logic       exp_bits [0:2047];
  logic       got_bits [0:2047];
  logic       prev_bits [0:2047];
  int         exp_n, got_n, prev_n;

  assign rd_data = mem[rd_ptr % 1024];

  ftx_seq uut (.clk(clk), .rst_n(rst_n), .frm_avail(frm_avail), .frm_len(frm_len),
               .rd_data(rd_data), .rd_en(rd_en), .bit_en(bit_en), .ser_bit(ser_bit),
               .ser_vld(ser_vld), .frm_done(frm_done));

  initial clk = 1'b0;
  always #10 clk = ~clk;

  // each entry: frame length, bit_en pattern, data seed, requirement code
  localparam int NVEC = 8;
  localparam int VEC [NVEC][4] = '{
    '{1, 0, 3, 4}, '{7, 0, 5, 5}, '{2, 1, 7, 3}, '{3, 2, 11, 3},
    '{6, 1, 13, 2}, '{12, 0, 17, 3}, '{16, 3, 19, 7}, '{4, 0, 0, 6}};

  function automatic string tag_name(input int c);
    case (c)
      2: return "R2";  3: return "R3";  4: return "R4";  5: return "R5";
      6: return "R6";  7: return "R7";  9: return "R9";  default: return "R11";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic logic [3:0] tb_gmul(input logic [3:0] a, input logic [3:0] b);
    logic [7:0] prod;
    prod = '0;
    for (int i = 0; i < 4; i++) if (b[i]) prod = prod ^ (8'(a) << i);
    for (int i = 7; i >= 4; i--) if (prod[i]) prod = prod ^ (8'h13 << (i - 4));
    return prod[3:0];
  endfunction

  function automatic bit en_pat(input int mode, input int cyc);
    case (mode)
      0: return 1'b1;
      1: return (cyc % 3) == 0;
      2: return (cyc % 2) == 1;
      default: return (cyc % 5) < 2;
    endcase
  endfunction

  task automatic calc_expected(input int base, input int len);
    logic [31:0] crc;
    logic [3:0]  syms [0:127];
    logic [3:0]  c [0:4];
    logic [3:0]  roots [0:3];
    logic [3:0]  p [0:3];
    logic [3:0]  fb;
    logic [7:0]  b;
    logic [6:0]  s;
    logic        k;
    int          ns, blk;
    roots[0] = 4'h2; roots[1] = 4'h4; roots[2] = 4'h8; roots[3] = 4'h3;
    c[0] = 4'h1; c[1] = 4'h0; c[2] = 4'h0; c[3] = 4'h0; c[4] = 4'h0;
    for (int r = 0; r < 4; r++) begin
      for (int j = 4; j >= 1; j--) c[j] = c[j-1] ^ tb_gmul(c[j], roots[r]);
      c[0] = tb_gmul(c[0], roots[r]);
    end
    crc = 32'hFFFFFFFF; ns = 0;
    for (int i = 0; i < len; i++) begin
      b = mem[(base + i) % 1024];
      for (int q = 0; q < 8; q++)
        crc = (crc[0] ^ b[q]) ? ((crc >> 1) ^ 32'hEDB88320) : (crc >> 1);
      syms[ns] = b[3:0]; syms[ns+1] = b[7:4]; ns += 2;
    end
    crc = ~crc;
    for (int q = 0; q < 8; q++) begin syms[ns] = crc[4*q +: 4]; ns++; end
    for (int q = 0; q < 4; q++) p[q] = 4'h0;
    exp_n = 0; blk = 0;
    for (int i = 0; i <= ns; i++) begin
      if (i < ns || blk != 0) begin
        if (i < ns) for (int q = 0; q < 4; q++) begin exp_bits[exp_n] = syms[i][q]; exp_n++; end
        while (blk < 11) begin
          fb = ((i < ns) ? syms[i] : 4'h0) ^ p[3];
          p[3] = p[2] ^ tb_gmul(fb, c[3]);
          p[2] = p[1] ^ tb_gmul(fb, c[2]);
          p[1] = p[0] ^ tb_gmul(fb, c[1]);
          p[0] = tb_gmul(fb, c[0]);
          blk++;
          if (i < ns) break;
        end
        if (blk == 11) begin
          for (int r = 3; r >= 0; r--)
            for (int q = 0; q < 4; q++) begin exp_bits[exp_n] = p[r][q]; exp_n++; end
          for (int q = 0; q < 4; q++) p[q] = 4'h0;
          blk = 0;
        end
      end
    end
    s = 7'h7F;
    for (int i = 0; i < exp_n; i++) begin
      k = s[6] ^ s[3];
      exp_bits[i] = exp_bits[i] ^ k;
      s = {s[5:0], k};
    end
  endtask

  task automatic run_frame(input int len, input int mode, input int seed, input string req);
    int  base, cyc, pops, dn, after_done, first_bad;
    bit  pend, done_ok, en_ok, prev_en;
    base = rd_ptr;
    for (int i = 0; i < len; i++)
      mem[(base + i) % 1024] = (seed == 0) ? 8'h00 : 8'((seed * 37 + i * 29 + 5) & 255);
    calc_expected(base, len);
    got_n = 0; pops = 0; dn = 0; after_done = 0; cyc = 0;
    pend = 1'b0; done_ok = 1'b0; en_ok = 1'b1; prev_en = 1'b0;
    while (after_done < 4 && cyc < 20000) begin
      @(negedge clk);
      if (pend) rd_ptr++;
      frm_len   = 8'(len);
      frm_avail = (cyc == 0);
      bit_en    = en_pat(mode, cyc);
      #1;
      pend = rd_en;
      if (rd_en) pops++;
      if (ser_vld) begin
        if (!prev_en) en_ok = 1'b0;
        if (got_n < 2048) got_bits[got_n] = ser_bit;
        got_n++;
      end
      if (frm_done) begin
        dn++;
        if (ser_vld && got_n == exp_n) done_ok = 1'b1;
      end
      if (dn > 0) after_done++;
      prev_en = bit_en;
      cyc++;
    end
    @(negedge clk);
    if (pend) rd_ptr++;
    bit_en = 1'b0;
    check(cyc < 20000, "R8 watchdog", cyc, 20000);
    check(got_n == exp_n, req, got_n, exp_n);
    first_bad = -1;
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (first_bad < 0 && got_bits[i] !== exp_bits[i]) first_bad = i;
    check(first_bad < 0, req, first_bad, -1);
    check(pops == len, "R2", pops, len);
    check(dn == 1 && done_ok, "R8", dn, 1);
    check(en_ok, "R7", 0, 1);
  endtask

  initial begin
    #(20 * 150000);
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
    $finish;
  end

  initial begin
    n_tests = 0; n_fail = 0; rd_ptr = 0;
    frm_avail = 1'b0; bit_en = 1'b0; frm_len = '0; rst_n = 1'b0;
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    check(!ser_vld && !frm_done && !rd_en, "R1", {ser_vld, frm_done, rd_en}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    check(!ser_vld && !frm_done && !rd_en, "R1", {ser_vld, frm_done, rd_en}, 0);

    // R10: bit slots while idle
    begin
      int seen;
      seen = 0;
      for (int i = 0; i < 20; i++) begin
        @(negedge clk);
        bit_en = 1'b1;
        #1;
        if (ser_vld || rd_en) seen++;
      end
      bit_en = 1'b0;
      check(seen == 0, "R10", seen, 0);
    end

    for (int v = 0; v < NVEC; v++)
      run_frame(VEC[v][0], VEC[v][1], VEC[v][2], tag_name(VEC[v][3]));

    // R9: empty frame
    run_frame(0, 0, 1, "R9");
    check(exp_n == 48, "R9", exp_n, 48);

    // R11: same frame twice, streams identical
    run_frame(5, 0, 9, "R11");
    prev_n = got_n;
    for (int i = 0; i < got_n && i < 2048; i++) prev_bits[i] = got_bits[i];
    begin
      int diff;
      run_frame(5, 2, 9, "R11");
      diff = (prev_n == got_n) ? 0 : 1;
      for (int i = 0; i < got_n && i < prev_n; i++) if (prev_bits[i] !== got_bits[i]) diff++;
      check(diff == 0, "R11", diff, 0);
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule